// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out the bit-level part of a small controller's instruction set. Each cycle it can accept one instruction, given as an opcode byte and a bit address. It reads the addressed bit, combines that bit with the carry flag, writes a single bit back, or tests the bit for a conditional branch. The 256-bit space it addresses is split into two halves. The lower half is a window of sixteen general-purpose RAM bytes held inside the block. The upper half lands on a few special-function bytes: an output port latch whose pins are read through `pin_i`, a status word that holds the carry flag in bit 7, an accumulator and an auxiliary register.

Results are registered. In the cycle after an instruction is accepted, the block shows the following: the new carry, the whole status word, a one-cycle byte write strobe with the byte address and the merged byte, and, for the three bit-test forms, a branch-valid flag with its taken outcome. Instruction fetch and the calculation of the branch target belong to the surrounding core.

Top module: `bool_proc`

## Requirements
- R1: After reset `carry_o`, `psw_o`, `wr_en_o` and `br_valid_o` are all 0, every RAM byte holds 0x00 and the port latch holds 0xFF.
- R2: Bit address `a` below 128 selects RAM byte 0x20 + a[6:3]. Bit address `a` of 128 or above selects the special byte at a & 0xF8. In both cases the bit is a[2:0]. `wr_addr_o` reports this byte address. The mapped special bytes are 0x90 (port), 0xD0 (status), 0xE0 and 0xF0.
- R3: Opcode 0x82 clears carry when the source bit is 0 and otherwise leaves carry unchanged. Opcode 0xB0 does the same with the inverted source bit.
- R4: Opcode 0x72 sets carry when the source bit is 1 and otherwise leaves carry unchanged. Opcode 0xA0 does the same with the inverted source bit.
- R5: The carry-combining opcodes (0x82, 0xB0, 0x72, 0xA0) and the bit-to-carry move never raise the write strobe. They change no stored bit, the addressed bit included, and no status bit other than carry.
- R6: Opcode 0xA2 copies the addressed bit into carry. Opcode 0x92 writes carry into the addressed bit.
- R7: Opcodes 0xC2, 0xD2 and 0xB2 clear, set and complement the addressed bit. The cycle after the instruction, `wr_en_o` pulses for one cycle and `wr_data_o` carries the stored byte with only that bit changed.
- R8: Opcodes 0xC3, 0xD3 and 0xB3 clear, set and complement carry without raising the write strobe.
- R9: Instructions that write the port byte (0x92, 0xC2, 0xD2, 0xB2, 0x10) take the other bits of that byte from the output latch. Instructions that only read a port bit use `pin_i`. For example, a latch holding 0x5D with bit 2 cleared becomes 0x59.
- R10: A bit write to addresses 0xD0–0xD7 changes the status word seen on `psw_o`, and a write to 0xD7 changes `carry_o`.
- R11: Opcodes 0x20 (jump if set), 0x30 (jump if clear) and 0x10 (jump if set, then clear) raise `br_valid_o` with the outcome on `br_taken_o`. Opcode 0x10 clears the bit, with a write strobe, only when the branch is taken.
- R12: Any other opcode, and any cycle with `op_valid` low, changes no state and raises neither the write strobe nor the branch flag.
- R13: A bit in an unmapped special byte reads as 0, and writing it stores nothing and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| op_code | input | 8 | Instruction opcode |
| op_bit | input | 8 | Bit address operand |
| pin_i | input | 8 | Levels on the port pins |
| carry_o | output | 1 | Current carry flag |
| psw_o | output | 8 | Current status word |
| wr_en_o | output | 1 | Byte write strobe for the previous instruction |
| wr_addr_o | output | 8 | Byte address of the write |
| wr_data_o | output | 8 | Merged byte written |
| br_valid_o | output | 1 | Previous instruction was a bit test |
| br_taken_o | output | 1 | Outcome of that bit test |

## Verification
On every cycle the assertions check four things: the address arithmetic behind each write strobe, the carry outcome of the carry clear and set opcodes, the rule that a carry-combining instruction neither strobes nor alters other status bits, and the rule that the set-then-clear branch strobes exactly when taken. Some behaviours depend on what was stored earlier, and only the bench's ordered scenarios can show them. These are: the slash forms leaving their source bit intact, port bytes being merged from the latch while plain reads see the pins, status-word bit writes reaching the carry, and unmapped special bytes reading as zero.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_ANL, K_ANLN, K_ORL, K_ORLN, K_MOVC, K_MOVB,
        K_CLRB, K_SETB, K_CPLB, K_CLRC, K_SETC, K_CPLC,
        K_JB, K_JNB, K_JBC
    } op_kind_e;

    function automatic op_kind_e decode_op(input logic [7:0] op);
        op_kind_e k;
        case (op)
            8'h82:   k = K_ANL;
            8'hB0:   k = K_ANLN;
            8'h72:   k = K_ORL;
            8'hA0:   k = K_ORLN;
            8'hA2:   k = K_MOVC;
            8'h92:   k = K_MOVB;
            8'hC2:   k = K_CLRB;
            8'hD2:   k = K_SETB;
            8'hB2:   k = K_CPLB;
            8'hC3:   k = K_CLRC;
            8'hD3:   k = K_SETC;
            8'hB3:   k = K_CPLC;
            8'h20:   k = K_JB;
            8'h30:   k = K_JNB;
            8'h10:   k = K_JBC;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    // instructions whose byte image is written back: port bytes come from the latch
    function automatic logic is_rmw(input op_kind_e k);
        return (k == K_MOVB) || (k == K_CLRB) || (k == K_SETB) ||
               (k == K_CPLB) || (k == K_JBC);
    endfunction

endpackage

// File: rtl/bp_addr_map.sv
module bp_addr_map #(
    parameter int               ADDR_W    = 8,
    parameter int               RAM_BYTES = 16,
    parameter logic [7:0]       RAM_BASE  = 8'h20,
    parameter int               NUM_SFR   = 4,
    parameter logic [NUM_SFR*8-1:0] SFR_MAP = {8'hF0, 8'hE0, 8'hD0, 8'h90},
    localparam int              RAM_IDX_W = $clog2(RAM_BYTES)
) (
    input  logic [ADDR_W-1:0]    bit_addr,
    output logic [7:0]           byte_addr,
    output logic [2:0]           bit_idx,
    output logic                 is_ram,
    output logic [RAM_IDX_W-1:0] ram_idx,
    output logic [NUM_SFR-1:0]   sfr_hit
);
    assign is_ram    = ~bit_addr[ADDR_W-1];
    assign ram_idx   = bit_addr[3 +: RAM_IDX_W];
    assign bit_idx   = bit_addr[2:0];
    assign byte_addr = is_ram ? (RAM_BASE + {{(8-RAM_IDX_W){1'b0}}, ram_idx})
                              : {bit_addr[ADDR_W-1:3], 3'b000};

    for (genvar i = 0; i < NUM_SFR; i++) begin : g_hit
        assign sfr_hit[i] = ~is_ram && (byte_addr == SFR_MAP[i*8 +: 8]);
    end
endmodule

// File: rtl/bp_bit_alu.sv
module bp_bit_alu
    import bp_pkg::*;
(
    input  op_kind_e kind,
    input  logic     src_bit,
    input  logic     carry,
    output logic     carry_nx,
    output logic     bit_nx,
    output logic     bit_we,
    output logic     br_valid,
    output logic     br_taken
);
    always_comb begin
        carry_nx = carry;
        bit_nx   = src_bit;
        bit_we   = 1'b0;
        br_valid = 1'b0;
        br_taken = 1'b0;
        case (kind)
            K_ANL:  carry_nx = carry & src_bit;
            K_ANLN: carry_nx = carry & ~src_bit;
            K_ORL:  carry_nx = carry | src_bit;
            K_ORLN: carry_nx = carry | ~src_bit;
            K_MOVC: carry_nx = src_bit;
            K_MOVB: begin bit_nx = carry;    bit_we = 1'b1; end
            K_CLRB: begin bit_nx = 1'b0;     bit_we = 1'b1; end
            K_SETB: begin bit_nx = 1'b1;     bit_we = 1'b1; end
            K_CPLB: begin bit_nx = ~src_bit; bit_we = 1'b1; end
            K_CLRC: carry_nx = 1'b0;
            K_SETC: carry_nx = 1'b1;
            K_CPLC: carry_nx = ~carry;
            K_JB:   begin br_valid = 1'b1; br_taken = src_bit;  end
            K_JNB:  begin br_valid = 1'b1; br_taken = ~src_bit; end
            K_JBC:  begin
                br_valid = 1'b1;
                br_taken = src_bit;
                bit_nx   = 1'b0;
                bit_we   = src_bit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bp_byte_merge.sv
module bp_byte_merge #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     old_byte,
    input  logic [IDX_W-1:0] idx,
    input  logic             new_bit,
    output logic [W-1:0]     merged
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign merged[i] = (idx == IDX_W'(i)) ? new_bit : old_byte[i];
    end
endmodule

// File: rtl/bool_proc.sv
module bool_proc
    import bp_pkg::*;
#(
    parameter int                   RAM_BYTES  = 16,
    parameter logic [7:0]           RAM_BASE   = 8'h20,
    parameter int                   NUM_SFR    = 4,
    parameter logic [NUM_SFR*8-1:0] SFR_MAP    = {8'hF0, 8'hE0, 8'hD0, 8'h90},
    parameter int                   PORT_IDX   = 0,
    parameter int                   PSW_IDX    = 1,
    parameter int                   CARRY_POS  = 7,
    parameter logic [7:0]           PORT_RESET = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic [7:0] op_bit,
    input  logic [7:0] pin_i,
    output logic       carry_o,
    output logic [7:0] psw_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       br_valid_o,
    output logic       br_taken_o
);
    localparam int RAM_IDX_W = $clog2(RAM_BYTES);

    typedef struct packed {
        logic [RAM_BYTES-1:0][7:0] ram;
        logic [NUM_SFR-1:0][7:0]   sfr;
        logic                      we;
        logic [7:0]                waddr;
        logic [7:0]                wdata;
        logic                      bv;
        logic                      bt;
    } state_t;

    state_t st_d, st_q;

    op_kind_e              kind;
    logic [7:0]            byte_addr;
    logic [2:0]            bit_idx;
    logic                  is_ram;
    logic [RAM_IDX_W-1:0]  ram_idx;
    logic [NUM_SFR-1:0]    sfr_hit;
    logic [7:0]            byte_rd;
    logic [7:0]            merged;
    logic                  src_bit, carry_now;
    logic                  carry_nx, bit_nx, bit_we, br_valid, br_taken;

    assign kind      = op_valid ? decode_op(op_code) : K_NONE;
    assign carry_now = st_q.sfr[PSW_IDX][CARRY_POS];

    bp_addr_map #(
        .ADDR_W(8), .RAM_BYTES(RAM_BYTES), .RAM_BASE(RAM_BASE),
        .NUM_SFR(NUM_SFR), .SFR_MAP(SFR_MAP)
    ) i_map (
        .bit_addr (op_bit),
        .byte_addr(byte_addr),
        .bit_idx  (bit_idx),
        .is_ram   (is_ram),
        .ram_idx  (ram_idx),
        .sfr_hit  (sfr_hit)
    );

    // source byte: port reads see pins unless the byte is being written back
    always_comb begin
        byte_rd = '0;
        if (is_ram) begin
            byte_rd = st_q.ram[ram_idx];
        end else begin
            for (int i = 0; i < NUM_SFR; i++) begin
                if (sfr_hit[i]) begin
                    if (i == PORT_IDX && !is_rmw(kind)) byte_rd = pin_i;
                    else                                byte_rd = st_q.sfr[i];
                end
            end
        end
    end

    assign src_bit = byte_rd[bit_idx];

    bp_bit_alu i_alu (
        .kind    (kind),
        .src_bit (src_bit),
        .carry   (carry_now),
        .carry_nx(carry_nx),
        .bit_nx  (bit_nx),
        .bit_we  (bit_we),
        .br_valid(br_valid),
        .br_taken(br_taken)
    );

    bp_byte_merge #(.W(8)) i_merge (
        .old_byte(byte_rd),
        .idx     (bit_idx),
        .new_bit (bit_nx),
        .merged  (merged)
    );

    always_comb begin
        logic do_wr;
        do_wr = bit_we && (is_ram || (|sfr_hit));
        st_d  = st_q;
        st_d.sfr[PSW_IDX][CARRY_POS] = carry_nx;
        if (do_wr) begin
            if (is_ram) st_d.ram[ram_idx] = merged;
            for (int i = 0; i < NUM_SFR; i++) begin
                if (sfr_hit[i]) st_d.sfr[i] = merged;
            end
        end
        st_d.we    = do_wr;
        st_d.waddr = byte_addr;
        st_d.wdata = merged;
        st_d.bv    = br_valid;
        st_d.bt    = br_taken;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.sfr[PORT_IDX] <= PORT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_o    = st_q.sfr[PSW_IDX][CARRY_POS];
    assign psw_o      = st_q.sfr[PSW_IDX];
    assign wr_en_o    = st_q.we;
    assign wr_addr_o  = st_q.waddr;
    assign wr_data_o  = st_q.wdata;
    assign br_valid_o = st_q.bv;
    assign br_taken_o = st_q.bt;
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter logic [7:0] RAM_BASE = 8'h20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic [7:0] op_bit,
    input logic       carry_o,
    input logic [7:0] psw_o,
    input logic       wr_en_o,
    input logic [7:0] wr_addr_o,
    input logic       br_valid_o,
    input logic       br_taken_o
);
    logic carry_comb_op;
    assign carry_comb_op = op_valid && (op_code == 8'h82 || op_code == 8'hB0 ||
                           op_code == 8'h72 || op_code == 8'hA0 || op_code == 8'hA2);

    // R2
    ram_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && !$past(op_bit[7]) |-> wr_addr_o == (RAM_BASE + {4'b0000, $past(op_bit[6:3])}));

    // R2
    sfr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && $past(op_bit[7]) |-> wr_addr_o == {$past(op_bit[7:3]), 3'b000});

    // R5
    carry_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_comb_op |=> !wr_en_o && (psw_o[6:0] == $past(psw_o[6:0])));

    // R8
    clr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 8'hC3 |=> !carry_o && !wr_en_o);

    // R8
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 8'hD3 |=> carry_o && !wr_en_o);

    // R11
    jbc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 8'h10 |=> br_valid_o && (wr_en_o == br_taken_o));

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !wr_en_o && !br_valid_o && $stable(psw_o));

    // R11
    branch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code != 8'h20 && op_code != 8'h30 && op_code != 8'h10 |=> !br_valid_o);
endmodule

bind bool_proc bp_checker i_bp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_bit    (op_bit),
    .carry_o   (carry_o),
    .psw_o     (psw_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .br_valid_o(br_valid_o),
    .br_taken_o(br_taken_o)
);

// File: tb/test_bool_proc.sv
module test_bool_proc;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 46;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = '0, op_bit = '0, pin_i = '0;
    logic       carry_o, wr_en_o, br_valid_o, br_taken_o;
    logic [7:0] psw_o, wr_addr_o, wr_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bool_proc i_bool_proc (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_bit(op_bit), .pin_i(pin_i), .carry_o(carry_o), .psw_o(psw_o),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .br_valid_o(br_valid_o), .br_taken_o(br_taken_o)
    );

    // {op, bit, pin, carry, we, addr, data, bv, taken, req}
    function automatic logic [47:0] vec(logic [7:0] op, logic [7:0] b, logic [7:0] pin,
                                        logic c, logic we, logic [7:0] a, logic [7:0] d,
                                        logic bv, logic tk, logic [3:0] req);
        return {op, b, pin, c, we, a, d, bv, tk, req};
    endfunction

    localparam logic [47:0] VEC [NV] = '{
        vec(8'hD3,8'h00,8'h00,1,0,8'h00,8'h00,0,0,4'd8),   // R8 set carry
        vec(8'h82,8'h00,8'h00,0,0,8'h00,8'h00,0,0,4'd3),   // R3 and with 0
        vec(8'hD3,8'h00,8'h00,1,0,8'h00,8'h00,0,0,4'd8),
        vec(8'hB0,8'h00,8'h00,1,0,8'h00,8'h00,0,0,4'd3),   // R3 and with /0 keeps
        vec(8'hD2,8'h05,8'h00,1,1,8'h20,8'h20,0,0,4'd7),   // R7 set bit
        vec(8'hB0,8'h05,8'h00,0,0,8'h00,8'h00,0,0,4'd3),   // R3 and with /1 clears
        vec(8'hA2,8'h05,8'h00,1,0,8'h00,8'h00,0,0,4'd5),   // R5 source bit survived
        vec(8'hC3,8'h00,8'h00,0,0,8'h00,8'h00,0,0,4'd8),
        vec(8'h72,8'h00,8'h00,0,0,8'h00,8'h00,0,0,4'd4),   // R4 or with 0 keeps
        vec(8'hA0,8'h00,8'h00,1,0,8'h00,8'h00,0,0,4'd4),   // R4 or with /0 sets
        vec(8'hB3,8'h00,8'h00,0,0,8'h00,8'h00,0,0,4'd8),   // R8 complement
        vec(8'hB3,8'h00,8'h00,1,0,8'h00,8'h00,0,0,4'd8),
        vec(8'h92,8'h7F,8'h00,1,1,8'h2F,8'h80,0,0,4'd6),   // R6 carry to top RAM bit
        vec(8'hB2,8'h7F,8'h00,1,1,8'h2F,8'h00,0,0,4'd7),
        vec(8'hB2,8'h79,8'h00,1,1,8'h2F,8'h02,0,0,4'd7),
        vec(8'hC2,8'h05,8'h00,1,1,8'h20,8'h00,0,0,4'd7),
        vec(8'hC2,8'h97,8'h00,1,1,8'h90,8'h7F,0,0,4'd9),   // R9 latch, not pins
        vec(8'hC2,8'h95,8'h00,1,1,8'h90,8'h5F,0,0,4'd9),
        vec(8'hC2,8'h91,8'h00,1,1,8'h90,8'h5D,0,0,4'd9),
        vec(8'hC2,8'h92,8'h00,1,1,8'h90,8'h59,0,0,4'd9),   // R9 0x5D -> 0x59
        vec(8'hC3,8'h00,8'h00,0,0,8'h00,8'h00,0,0,4'd8),
        vec(8'hA2,8'h91,8'h02,1,0,8'h00,8'h00,0,0,4'd9),   // R9 read sees pin
        vec(8'hA2,8'h90,8'h00,0,0,8'h00,8'h00,0,0,4'd9),
        vec(8'hD2,8'h91,8'hFF,0,1,8'h90,8'h5B,0,0,4'd9),
        vec(8'hD2,8'hD2,8'h00,0,1,8'hD0,8'h04,0,0,4'd10),  // R10 status bit
        vec(8'hD2,8'hD7,8'h00,1,1,8'hD0,8'h84,0,0,4'd10),  // R10 carry via address
        vec(8'hC2,8'hD7,8'h00,0,1,8'hD0,8'h04,0,0,4'd10),
        vec(8'hD3,8'h00,8'h00,1,0,8'h00,8'h00,0,0,4'd8),
        vec(8'h82,8'hD2,8'h00,1,0,8'h00,8'h00,0,0,4'd3),
        vec(8'h20,8'h79,8'h00,1,0,8'h00,8'h00,1,1,4'd11),  // R11 jump if set
        vec(8'h30,8'h79,8'h00,1,0,8'h00,8'h00,1,0,4'd11),
        vec(8'h10,8'h78,8'h00,1,0,8'h00,8'h00,1,0,4'd11),  // R11 not taken, no write
        vec(8'h10,8'h79,8'h00,1,1,8'h2F,8'h00,1,1,4'd11),  // R11 taken, clears
        vec(8'h20,8'h79,8'h00,1,0,8'h00,8'h00,1,0,4'd11),
        vec(8'h30,8'h79,8'h00,1,0,8'h00,8'h00,1,1,4'd11),
        vec(8'h20,8'h90,8'h00,1,0,8'h00,8'h00,1,0,4'd9),   // R9 test reads pin
        vec(8'h10,8'h91,8'h00,1,1,8'h90,8'h59,1,1,4'd9),   // R9 test-clear uses latch
        vec(8'hD2,8'h80,8'h00,1,0,8'h00,8'h00,0,0,4'd13),  // R13 unmapped write
        vec(8'hC3,8'h00,8'h00,0,0,8'h00,8'h00,0,0,4'd8),
        vec(8'h72,8'h80,8'hFF,0,0,8'h00,8'h00,0,0,4'd13),  // R13 reads 0
        vec(8'hA0,8'h80,8'h00,1,0,8'h00,8'h00,0,0,4'd13),
        vec(8'h00,8'h05,8'h00,1,0,8'h00,8'h00,0,0,4'd12),  // R12 unknown opcode
        vec(8'hA5,8'hD7,8'h00,1,0,8'h00,8'h00,0,0,4'd12),
        vec(8'hD2,8'hE3,8'h00,1,1,8'hE0,8'h08,0,0,4'd2),   // R2 high mapping
        vec(8'hB2,8'hF0,8'h00,1,1,8'hF0,8'h01,0,0,4'd2),
        vec(8'h92,8'hF7,8'h00,1,1,8'hF0,8'h81,0,0,4'd6)
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic issue(input logic v, input logic [7:0] op, input logic [7:0] b,
                         input logic [7:0] pin);
        op_valid = v; op_code = op; op_bit = b; pin_i = pin;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(1, {7'b0, carry_o}, 8'h00);
        chk(1, psw_o, 8'h00);
        chk(1, {6'b0, wr_en_o, br_valid_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            int req;
            v = VEC[i];
            req = int'(v[3:0]);
            issue(1'b1, v[47:40], v[39:32], v[31:24]);
            chk(req, {7'b0, carry_o}, {7'b0, v[23]});
            chk(req, {7'b0, wr_en_o}, {7'b0, v[22]});
            if (v[22]) begin
                chk(req, wr_addr_o, v[21:14]);
                chk(req, wr_data_o, v[13:6]);
            end
            chk(req, {7'b0, br_valid_o}, {7'b0, v[5]});
            if (v[5]) chk(req, {7'b0, br_taken_o}, {7'b0, v[4]});
        end
        // R10 status word after the run, R5 no stray flag changes
        chk(10, psw_o, 8'h84);

        // R12 op_valid low: set-bit request ignored, then probe the bit
        issue(1'b0, 8'hD2, 8'h05, 8'h00);
        chk(12, {7'b0, wr_en_o}, 8'h00);
        issue(1'b1, 8'h20, 8'h05, 8'h00);
        chk(12, {6'b0, br_valid_o, br_taken_o}, 8'h02);

        // R1 reset restores RAM and port latch
        do_reset();
        chk(1, psw_o, 8'h00);
        issue(1'b1, 8'h20, 8'h79, 8'h00);
        chk(1, {6'b0, br_valid_o, br_taken_o}, 8'h02);
        issue(1'b1, 8'hD2, 8'h90, 8'h00);
        chk(1, wr_data_o, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule